// File: doc/BRIEF.md
# Multi-Mode PWM Timer

This block is an up/down timer with one compare channel and a single waveform pin. Software-side logic writes a control byte and a compare value through two write strobes. A prescaler turns the system clock into count enables. The counter then runs as a plain wrapping counter, a fast single-slope PWM, a dual-slope phase-correct PWM, or a clear-on-compare counter whose output toggles on every match.

In the two PWM modes the compare value is double-buffered. A write lands in a holding register and reaches the comparator only at the period boundary: the wrap from top to zero in fast mode, and the bottom turn in phase-correct mode. This keeps a duty update from cutting a period short or adding a spike. In the other two modes a write takes effect at once. An output-mode field selects no drive, true polarity or inverted polarity. A separate enable input gates the pin, and the pin stays low while that input is clear.

The counter width is a parameter, 8 bits by default. The compare register has the same width. The top of the count is the all-ones value of that width.

Top module: `tmr_pwm_unit`

## Requirements
- R1: After synchronous reset the count output is 0, the pin is low, the control byte is 0 (halted) and the compare value is 0.
- R2: Control byte layout: bits 1:0 waveform mode (00 wrap counter, 01 phase-correct PWM, 10 clear-on-compare, 11 fast PWM); bits 3:2 output mode; bits 6:4 clock select; bit 7 has no effect.
- R3: Clock-select codes 000, 110 and 111 halt the timer: the count holds its value and the pin is low.
- R4: Clock-select codes 001, 010, 011, 100 and 101 advance the count once every 1, 8, 64, 256 and 1024 clocks respectively.
- R5: In fast PWM the count runs 0 up to top and wraps to 0; with true polarity the pin is high while count <= compare.
- R6: In phase-correct PWM the count rises from 0 to top, then falls back to 0; the pin is high while count < compare, and stays high throughout when compare equals top.
- R7: In clear-on-compare mode the count goes to 0 on the count step after it equals the compare value, and the waveform toggles on each such match.
- R8: In wrap-counter mode the count runs 0 to top and wraps, and the waveform toggles each time the count steps away from a value equal to compare.
- R9: Output mode 10 drives the waveform with true polarity, 11 drives it inverted, and 00 or 01 keep the pin low.
- R10: The pin is low whenever the pin-enable input is low.
- R11: In fast PWM a new compare value takes effect at the wrap from top to 0; in phase-correct PWM at the step away from 0; in the other two modes it takes effect on the clock after the write.
- R12: A compare value of 0 gives a pin high for one count per period in fast PWM and a pin that stays low in phase-correct PWM; a compare value of top gives a pin that stays high in both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte write data |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | CNT_W | Compare value write data |
| pin_oe | input | 1 | Pin enable; the pin is held low when clear |
| pwm_pin | output | 1 | Waveform output pin |
| count_o | output | CNT_W | Current counter value |

## Verification
The bench builds the timer with CNT_W set to 4, so the top of the count is 15. Complete fast and phase-correct periods then take a few dozen clocks. Even at divide-by-1024, a whole pass of the counter around its wrap fits within about sixteen thousand clocks. At that width the corner duty values 0 and top, and the buffered compare update at both period boundaries, can be reached within a short run.

// File: rtl/tmr_pwm_pkg.sv
`timescale 1ns/1ps
package tmr_pwm_pkg;

    typedef enum logic [1:0] {
        WM_WRAP  = 2'b00,
        WM_PHASE = 2'b01,
        WM_CTC   = 2'b10,
        WM_FAST  = 2'b11
    } wave_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_RSVD   = 2'b01,
        OM_TRUE   = 2'b10,
        OM_INVERT = 2'b11
    } out_mode_e;

    // Seven useful bits of the control byte; bit 7 is dropped at the top.
    typedef struct packed {
        logic [2:0] csel;
        out_mode_e  omode;
        wave_mode_e wmode;
    } ctrl_t;

    localparam int MAX_SHIFT = 10;
    localparam int PRE_W     = MAX_SHIFT;

    function automatic logic [3:0] csel_shift(input logic [2:0] code);
        case (code)
            3'd2:    return 4'd3;
            3'd3:    return 4'd6;
            3'd4:    return 4'd8;
            3'd5:    return 4'd10;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic csel_run(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction

    function automatic logic is_pwm(input wave_mode_e m);
        return (m == WM_FAST) || (m == WM_PHASE);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale
    import tmr_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] csel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;
    logic             run;

    always_comb begin
        run   = csel_run(csel);
        span  = (PRE_W+1)'(1) << csel_shift(csel);
        limit = PRE_W'(span - 1'b1);
        tick  = run && (pre_q >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // R3: a halted prescaler restarts from zero
    assert_pre_clear_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_q == '0));

endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count
    import tmr_pwm_pkg::*;
#(
    parameter int W = 8
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  wave_mode_e   wmode,
    input  logic [W-1:0] ocr,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic         up_q;
    logic         up_d;
    logic [W-1:0] cnt_d;

    always_comb begin
        up_d  = 1'b1;
        cnt_d = cnt_q + 1'b1;
        case (wmode)
            WM_CTC: begin
                if (cnt_q == ocr)
                    cnt_d = '0;
            end
            WM_PHASE: begin
                if (cnt_q == TOP)
                    up_d = 1'b0;
                else if (cnt_q == '0)
                    up_d = 1'b1;
                else
                    up_d = up_q;
                cnt_d = up_d ? cnt_q + 1'b1 : cnt_q - 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
        end
    end

    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    assert_fast_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (wmode == WM_FAST && tick && cnt_q == TOP) |=> (cnt_q == '0));

    assert_phase_turn_top_R6: assert property (@(posedge clk) disable iff (rst)
        (wmode == WM_PHASE && tick && cnt_q == TOP) |=> (cnt_q == TOP - 1'b1));

    assert_phase_turn_bot_R6: assert property (@(posedge clk) disable iff (rst)
        (wmode == WM_PHASE && tick && cnt_q == '0) |=> (cnt_q == W'(1)));

    assert_ctc_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wmode == WM_CTC && tick && cnt_q == ocr) |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_compare.sv
`timescale 1ns/1ps
module tmr_compare
    import tmr_pwm_pkg::*;
#(
    parameter int W = 8
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  wave_mode_e   wmode,
    input  logic [W-1:0] cnt,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] ocr_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] hold_q;
    logic [W-1:0] live_q;
    logic         pwm;
    logic         edge_hit;
    logic         load;

    always_comb begin
        pwm      = is_pwm(wmode);
        edge_hit = (wmode == WM_FAST) ? (cnt == TOP) : (cnt == '0);
        load     = !pwm || (tick && edge_hit);
        ocr_o    = pwm ? live_q : hold_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            live_q <= '0;
        end else begin
            if (cmp_we)
                hold_q <= cmp_wdata;
            if (load)
                live_q <= hold_q;
        end
    end

    // R11: the live compare value stays put between period boundaries
    assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (pwm && !(tick && edge_hit)) |=> $stable(live_q));

endmodule

// File: rtl/tmr_wave.sv
`timescale 1ns/1ps
module tmr_wave
    import tmr_pwm_pkg::*;
#(
    parameter int W = 8
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  wave_mode_e   wmode,
    input  out_mode_e    omode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ocr,
    input  logic         pin_oe,
    output logic         pin
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic tog_q;
    logic raw;
    logic driven;
    logic wave;

    always_ff @(posedge clk) begin
        if (rst)
            tog_q <= 1'b0;
        else if (tick && !is_pwm(wmode) && cnt == ocr)
            tog_q <= ~tog_q;
    end

    always_comb begin
        case (wmode)
            WM_FAST:  raw = (cnt <= ocr);
            WM_PHASE: raw = (ocr == TOP) || (cnt < ocr);
            default:  raw = tog_q;
        endcase
        driven = run && (omode == OM_TRUE || omode == OM_INVERT);
        wave   = driven ? (raw ^ (omode == OM_INVERT)) : 1'b0;
        pin    = pin_oe && wave;
    end

    assert_pin_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !pin_oe |-> !pin);

    assert_off_mode_R9: assert property (@(posedge clk) disable iff (rst)
        (omode == OM_OFF || omode == OM_RSVD) |-> !pin);

    assert_halt_low_R3: assert property (@(posedge clk) disable iff (rst)
        !run |-> !pin);

endmodule

// File: rtl/tmr_pwm_unit.sv
`timescale 1ns/1ps
module tmr_pwm_unit
    import tmr_pwm_pkg::*;
#(
    parameter int CNT_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             pin_oe,
    output logic             pwm_pin,
    output logic [CNT_W-1:0] count_o
);
    ctrl_t            ctrl_q;
    logic             tick;
    logic             run;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ocr;
    logic             unused_spare;

    assign unused_spare = ctrl_wdata[7];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= ctrl_t'(ctrl_wdata[6:0]);
    end

    assign run     = csel_run(ctrl_q.csel);
    assign count_o = cnt;

    tmr_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .csel (ctrl_q.csel),
        .tick (tick)
    );

    tmr_compare #(.W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wmode     (ctrl_q.wmode),
        .cnt       (cnt),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .ocr_o     (ocr)
    );

    tmr_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wmode (ctrl_q.wmode),
        .ocr   (ocr),
        .cnt_q (cnt)
    );

    tmr_wave #(.W(CNT_W)) u_wave (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (run),
        .wmode  (ctrl_q.wmode),
        .omode  (ctrl_q.omode),
        .cnt    (cnt),
        .ocr    (ocr),
        .pin_oe (pin_oe),
        .pin    (pwm_pin)
    );

    // R1: state right after reset
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (count_o == '0 && !pwm_pin));

endmodule

// File: tb/tmr_pwm_unit_test.sv
`timescale 1ns/1ps
module tmr_pwm_unit_test;
    localparam int W = 4;
    localparam logic [W-1:0] TOPV = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctrl_we = 1'b0;
    logic [7:0]   ctrl_wdata = '0;
    logic         cmp_we = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         pin_oe = 1'b0;
    logic         pwm_pin;
    logic [W-1:0] count_o;

    int    tests_run = 0;
    int    tests_failed = 0;
    bit    done = 0;
    string cur_req = "R1";

    tmr_pwm_unit #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .pin_oe(pin_oe),
        .pwm_pin(pwm_pin), .count_o(count_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- scoreboard: reference model pushes, monitor pops ----------
    typedef struct packed { logic [W-1:0] cnt; logic wave; } exp_t;
    exp_t expq[$];

    logic [7:0]   m_ctrl;
    logic [W-1:0] m_hold, m_live, m_cnt;
    logic         m_up, m_tog;
    int           m_pre;

    function automatic int ratio_of(input logic [2:0] c);
        case (c)
            3'd1: return 1;
            3'd2: return 8;
            3'd3: return 64;
            3'd4: return 256;
            3'd5: return 1024;
            default: return 0;
        endcase
    endfunction

    function automatic logic mode_pwm(input logic [1:0] wm);
        return wm == 2'b11 || wm == 2'b01;
    endfunction

    function automatic logic exp_wave();
        logic [W-1:0] oc;
        logic r;
        oc = mode_pwm(m_ctrl[1:0]) ? m_live : m_hold;
        if (ratio_of(m_ctrl[6:4]) == 0 || !m_ctrl[3]) return 1'b0;
        case (m_ctrl[1:0])
            2'b11:   r = (m_cnt <= oc);
            2'b01:   r = (oc == TOPV) || (m_cnt < oc);
            default: r = m_tog;
        endcase
        return r ^ m_ctrl[2];
    endfunction

    always @(posedge clk) begin
        logic         stp;
        logic [W-1:0] oc;
        logic [1:0]   wm;
        exp_t         it;
        if (rst) begin
            m_ctrl = '0; m_hold = '0; m_live = '0; m_cnt = '0;
            m_up = 1'b1; m_tog = 1'b0; m_pre = 0;
        end else begin
            wm  = m_ctrl[1:0];
            oc  = mode_pwm(wm) ? m_live : m_hold;
            stp = 1'b0;
            if (ratio_of(m_ctrl[6:4]) == 0) m_pre = 0;
            else begin
                m_pre++;
                if (m_pre >= ratio_of(m_ctrl[6:4])) begin stp = 1'b1; m_pre = 0; end
            end
            if (!mode_pwm(wm)) begin
                if (stp && m_cnt == oc) m_tog = ~m_tog;
                m_live = m_hold;
            end else if (stp && ((wm == 2'b11 && m_cnt == TOPV) || (wm == 2'b01 && m_cnt == 0))) begin
                m_live = m_hold;
            end
            if (stp) begin
                if (wm == 2'b10 && m_cnt == oc) m_cnt = '0;
                else if (wm == 2'b01) begin
                    if (m_cnt == TOPV) m_up = 1'b0;
                    else if (m_cnt == 0) m_up = 1'b1;
                    m_cnt = m_up ? m_cnt + 1'b1 : m_cnt - 1'b1;
                end else m_cnt = m_cnt + 1'b1;
            end
            if (ctrl_we) m_ctrl = ctrl_wdata;
            if (cmp_we)  m_hold = cmp_wdata;
        end
        it.cnt  = m_cnt;
        it.wave = exp_wave();
        expq.push_back(it);
    end

    always @(negedge clk) begin
        exp_t e;
        if (!done && expq.size() > 0) begin
            e = expq.pop_front();
            check(count_o == e.cnt, {cur_req, " scoreboard count"}, int'(count_o), int'(e.cnt));
            check(pwm_pin == (e.wave & pin_oe), {cur_req, " scoreboard pin"}, int'(pwm_pin), int'(e.wave & pin_oe));
        end
    end

    // ---------------- driver tasks ----------------
    function automatic logic [7:0] mk(input logic [2:0] cs, input logic [1:0] om, input logic [1:0] wm);
        return {1'b0, cs, om, wm};
    endfunction

    task automatic start(input logic [7:0] ctrl, input logic [W-1:0] ocr, input logic oe);
        @(posedge clk); #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0; cmp_we = 1'b1; cmp_wdata = ocr; pin_oe = oe;
        @(posedge clk); #1 cmp_we = 1'b0; ctrl_we = 1'b1; ctrl_wdata = ctrl;
        @(posedge clk); #1 ctrl_we = 1'b0;
    endtask

    task automatic write_ctrl(input logic [7:0] ctrl);
        @(posedge clk); #1 ctrl_we = 1'b1; ctrl_wdata = ctrl;
        @(posedge clk); #1 ctrl_we = 1'b0;
    endtask

    task automatic measure(input int n, output int highs, output int pchg, output int cchg, output int cmax);
        logic         pp;
        logic [W-1:0] pc;
        highs = 0; pchg = 0; cchg = 0;
        @(negedge clk);
        pp = pwm_pin; pc = count_o; cmax = int'(count_o);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_pin) highs++;
            if (pwm_pin != pp) pchg++;
            if (count_o != pc) cchg++;
            if (int'(count_o) > cmax) cmax = int'(count_o);
            pp = pwm_pin; pc = count_o;
        end
    endtask

    task automatic wait_count(input logic [W-1:0] v);
        do @(negedge clk); while (count_o != v);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            tests_run++; tests_failed++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        int h, pc, cc, mx, c0;
        pin_oe = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        check(count_o == 0, "R1 reset count", int'(count_o), 0);
        check(pwm_pin == 0, "R1 reset pin", int'(pwm_pin), 0);

        // R5 fast PWM, duty 5 of 0..15 -> 6 high counts per 16
        cur_req = "R5";
        start(mk(3'd1, 2'b10, 2'b11), 4'd5, 1'b1);
        repeat (20) @(negedge clk);
        measure(32, h, pc, cc, mx);
        check(h == 12, "R5 fast duty highs", h, 12);

        // R2 bit 7 has no effect
        cur_req = "R2";
        start(8'h80 | mk(3'd1, 2'b10, 2'b11), 4'd5, 1'b1);
        repeat (20) @(negedge clk);
        measure(32, h, pc, cc, mx);
        check(h == 12, "R2 spare bit ignored", h, 12);

        // R9 inverted and off output modes
        cur_req = "R9";
        start(mk(3'd1, 2'b11, 2'b11), 4'd5, 1'b1);
        repeat (20) @(negedge clk);
        measure(32, h, pc, cc, mx);
        check(h == 20, "R9 inverted highs", h, 20);
        start(mk(3'd1, 2'b01, 2'b11), 4'd5, 1'b1);
        measure(32, h, pc, cc, mx);
        check(h == 0, "R9 mode 01 pin low", h, 0);
        start(mk(3'd1, 2'b00, 2'b11), 4'd5, 1'b1);
        measure(32, h, pc, cc, mx);
        check(h == 0, "R9 mode 00 pin low", h, 0);

        // R10 pin enable
        cur_req = "R10";
        start(mk(3'd1, 2'b10, 2'b11), 4'd5, 1'b0);
        measure(32, h, pc, cc, mx);
        check(h == 0, "R10 disabled pin low", h, 0);
        pin_oe = 1'b1;
        measure(32, h, pc, cc, mx);
        check(h == 12, "R10 enabled pin drives", h, 12);

        // R12 corner compare values
        cur_req = "R12";
        start(mk(3'd1, 2'b10, 2'b11), 4'd0, 1'b1);
        repeat (20) @(negedge clk);
        measure(32, h, pc, cc, mx);
        check(h == 2, "R12 fast compare 0 spike", h, 2);
        start(mk(3'd1, 2'b10, 2'b11), TOPV, 1'b1);
        repeat (20) @(negedge clk);
        measure(32, h, pc, cc, mx);
        check(h == 32, "R12 fast compare top high", h, 32);
        start(mk(3'd1, 2'b10, 2'b01), 4'd0, 1'b1);
        repeat (20) @(negedge clk);
        measure(60, h, pc, cc, mx);
        check(h == 0, "R12 phase compare 0 low", h, 0);
        start(mk(3'd1, 2'b10, 2'b01), TOPV, 1'b1);
        repeat (20) @(negedge clk);
        measure(60, h, pc, cc, mx);
        check(h == 60, "R12 phase compare top high", h, 60);

        // R6 phase-correct: 30-count period, 9 high for compare 5
        cur_req = "R6";
        start(mk(3'd1, 2'b10, 2'b01), 4'd5, 1'b1);
        repeat (20) @(negedge clk);
        measure(60, h, pc, cc, mx);
        check(h == 18, "R6 phase duty highs", h, 18);
        check(mx == 15, "R6 phase reaches top", mx, 15);

        // R7 clear-on-compare, compare 3: toggles every 4 counts
        cur_req = "R7";
        start(mk(3'd1, 2'b10, 2'b10), 4'd3, 1'b1);
        repeat (10) @(negedge clk);
        measure(32, h, pc, cc, mx);
        check(pc == 8, "R7 ctc toggles", pc, 8);
        check(mx == 3, "R7 ctc count max", mx, 3);

        // R8 wrap counter, compare 7: one toggle per 16 counts
        cur_req = "R8";
        start(mk(3'd1, 2'b10, 2'b00), 4'd7, 1'b1);
        repeat (10) @(negedge clk);
        measure(64, h, pc, cc, mx);
        check(pc == 4, "R8 wrap toggles", pc, 4);
        check(mx == 15, "R8 wrap reaches top", mx, 15);

        // R4 prescale ratios: 8 count steps per 8*ratio clocks
        cur_req = "R4";
        for (int k = 1; k <= 5; k++) begin
            start(mk(3'(k), 2'b10, 2'b00), 4'd0, 1'b1);
            repeat (4) @(negedge clk);
            measure(8 * ratio_of(3'(k)), h, pc, cc, mx);
            check(cc == 8, "R4 prescale count steps", cc, 8);
        end

        // R3 halt via 000, 110 and 111
        cur_req = "R3";
        for (int k = 0; k < 3; k++) begin
            start(mk(3'd1, 2'b10, 2'b11), TOPV, 1'b1);
            repeat (7) @(negedge clk);
            write_ctrl(mk(k == 0 ? 3'd0 : (k == 1 ? 3'd6 : 3'd7), 2'b10, 2'b11));
            @(negedge clk);
            c0 = int'(count_o);
            measure(20, h, pc, cc, mx);
            check(cc == 0, "R3 halted count holds", cc, 0);
            check(int'(count_o) == c0, "R3 halted count value", int'(count_o), c0);
            check(h == 0, "R3 halted pin low", h, 0);
        end

        // R11 buffered compare, fast mode
        cur_req = "R11";
        start(mk(3'd1, 2'b10, 2'b11), 4'd5, 1'b1);
        wait_count(4'd0);
        wait_count(4'd2);
        cmp_we = 1'b1; cmp_wdata = 4'd10;
        @(negedge clk); cmp_we = 1'b0;
        wait_count(4'd8);
        check(pwm_pin == 0, "R11 fast old compare kept", int'(pwm_pin), 0);
        wait_count(4'd0);
        wait_count(4'd8);
        check(pwm_pin == 1, "R11 fast new compare after wrap", int'(pwm_pin), 1);

        // R11 buffered compare, phase-correct mode
        start(mk(3'd1, 2'b10, 2'b01), 4'd5, 1'b1);
        wait_count(4'd10);
        cmp_we = 1'b1; cmp_wdata = 4'd12;
        @(negedge clk); cmp_we = 1'b0;
        wait_count(TOPV);
        wait_count(4'd8);
        check(pwm_pin == 0, "R11 phase old compare kept", int'(pwm_pin), 0);
        wait_count(4'd0);
        wait_count(4'd8);
        check(pwm_pin == 1, "R11 phase new compare after bottom", int'(pwm_pin), 1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule